// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block keeps the control address register of a microcoded processor. It computes the address of the next microinstruction on every clock edge. The microinstruction that is running supplies three things: a next-address field, a three-bit condition-select code and a one-bit load-source select. The instruction register supplies an opcode. The datapath supplies four status flags: carry, overflow, zero and negative. The register's value drives the control memory address directly.

A condition multiplexer picks one of eight inputs:

- two constants,
- the four flags taken as they are,
- carry and zero, each inverted.

If the picked condition is 1, the register loads a new address. The load-source select decides whether that address is the next-address field or the opcode. If the picked condition is 0, the register steps to the following address. This one mechanism covers plain sequencing, unconditional jumps, conditional branches on the flags and dispatch on the opcode.

Top module: `useq_car`

## Requirements
- R1: When `rst` is high at a rising clock edge, `car` becomes 0 after that edge.
- R2: Reset wins over a load or an increment that would happen in the same cycle, including a jump with condition code 1 when the register already holds a non-zero value.
- R3: Condition code 0 (constant false) makes `car` increase by one on the next edge, whatever the flags and sources are.
- R4: Condition code 1 (constant true) makes `car` load the selected source on the next edge, whatever the flags are.
- R5: Codes 2, 3, 4 and 5 select carry, overflow, zero and negative. A selected flag at 1 causes a load and a selected flag at 0 causes an increment.
- R6: Code 6 loads when carry is 0 and code 7 loads when zero is 0. Otherwise both increment.
- R7: On a load, `src_sel` = 0 takes `nxt_addr` and `src_sel` = 1 takes `opcode`.
- R8: An increment from 0x1FFFF wraps `car` to 0.
- R9: Flags that the current code does not select have no effect on `car`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_addr | input | 17 | Next-address field of the current microinstruction |
| cond_sel | input | 3 | Condition code: 0 false, 1 true, 2 C, 3 V, 4 Z, 5 N, 6 not C, 7 not Z |
| src_sel | input | 1 | Load source: 0 next-address field, 1 opcode |
| opcode | input | 17 | Opcode from the instruction register |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| car | output | 17 | Control address register, drives the control memory address |

## Verification
Reset can land in the same cycle as a taken branch. To provoke this, the bench first jumps to a non-zero address. It then holds `rst` high together with condition code 1 and a non-zero load value, and it expects 0 rather than the load value. A second collision happens when an increment from the top address meets the wrap. The bench loads 0x1FFFF and then increments it, expecting 0. The main sweep runs every condition code against all sixteen flag patterns and both load sources, and it compares each edge with an arithmetic model.

// File: rtl/useq_car.sv
module useq_car #(
  parameter int AW = 17,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nxt_addr,
  input  logic [2:0]    cond_sel,
  input  logic          src_sel,
  input  logic [AW-1:0] opcode,
  input  logic          flag_c,
  input  logic          flag_v,
  input  logic          flag_z,
  input  logic          flag_n,
  output logic [AW-1:0] car
);

  logic [7:0]    cond_vec;
  logic          take;
  logic [AW-1:0] load_val;

  assign cond_vec = {~flag_z, ~flag_c, flag_n, flag_z, flag_v, flag_c, 1'b1, 1'b0};
  assign take     = cond_vec[cond_sel];
  assign load_val = src_sel ? opcode : nxt_addr;

  always_ff @(posedge clk) begin
    if (rst)
      car <= RESET_ADDR;
    else if (take)
      car <= load_val;
    else
      car <= car + 1'b1;
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk)
    if (rst_d) p_reset_clear_r1: assert (car == RESET_ADDR);

  p_incr_false_r3: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd0) |=> car == AW'($past(car) + 1'b1));

  p_jump_field_r4: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd1 && !src_sel) |=> car == $past(nxt_addr));

  p_jump_opcode_r7: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd1 && src_sel) |=> car == $past(opcode));

  p_carry_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd2 && !flag_c) |=> car == AW'($past(car) + 1'b1));

  p_notzero_set_r6: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'd7 && flag_z) |=> car == AW'($past(car) + 1'b1));

endmodule

// File: tb/useq_car_bench.sv
module useq_car_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] nxt_addr = '0;
  logic [2:0]    cond_sel = '0;
  logic          src_sel = 1'b0;
  logic [AW-1:0] opcode = '0;
  logic          flag_c = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_n = 1'b0;
  logic [AW-1:0] car;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] model = '0;

  always #10 clk = ~clk;

  useq_car #(.AW(AW)) u_useq_car (
    .clk(clk), .rst(rst), .nxt_addr(nxt_addr), .cond_sel(cond_sel),
    .src_sel(src_sel), .opcode(opcode), .flag_c(flag_c), .flag_v(flag_v),
    .flag_z(flag_z), .flag_n(flag_n), .car(car)
  );

  function automatic logic cond_of(input logic [2:0] k, input logic [3:0] f);
    case (k)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return f[0];
      3'd3: return f[1];
      3'd4: return f[2];
      3'd5: return f[3];
      3'd6: return ~f[0];
      default: return ~f[2];
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] k, input logic s);
    if (k == 3'd0) return "R3/R9";
    if (k == 3'd1) return s ? "R4/R7" : "R4";
    if (k <= 3'd5) return "R5/R9";
    return "R6/R9";
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (car !== exp) begin
      errors++;
      $display("FAIL %s: car=%h expected=%h", req, car, exp);
    end
  endtask

  task automatic step(input logic r, input logic [2:0] k, input logic [3:0] f,
                      input logic s, input logic [AW-1:0] na, input logic [AW-1:0] op,
                      input string req);
    @(negedge clk);
    rst = r; cond_sel = k; src_sel = s; nxt_addr = na; opcode = op;
    {flag_n, flag_z, flag_v, flag_c} = f;
    if (r) model = '0;
    else if (cond_of(k, f)) model = s ? op : na;
    else model = AW'(model + 1);
    @(posedge clk);
    #5;
    check(req, model);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: car=%h expected=%h", car, model);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    step(1'b1, 3'd1, 4'hF, 1'b0, 17'h1ABCD, 17'h0F0F0, "R1");
    step(1'b0, 3'd0, 4'h0, 1'b0, 17'h00000, 17'h00000, "R3");
    for (int k = 0; k < 8; k++)
      for (int f = 0; f < 16; f++)
        for (int s = 0; s < 2; s++) begin
          logic [AW-1:0] na, op;
          na = AW'(k * 4099 + f * 257 + s * 31 + 5);
          op = AW'(~na ^ 17'h0F0F3);
          step(1'b0, 3'(k), 4'(f), 1'(s), na, op, tag_of(3'(k), 1'(s)));
        end
    step(1'b0, 3'd1, 4'h0, 1'b1, 17'h00001, 17'h1FFFF, "R7");
    step(1'b0, 3'd0, 4'hF, 1'b1, 17'h00001, 17'h00002, "R8");
    step(1'b0, 3'd0, 4'h0, 1'b0, 17'h1FFFF, 17'h1FFFF, "R8");
    step(1'b0, 3'd1, 4'h0, 1'b0, 17'h12345, 17'h0AAAA, "R4");
    step(1'b0, 3'd0, 4'h0, 1'b0, 17'h00000, 17'h00000, "R3");
    step(1'b1, 3'd1, 4'hF, 1'b1, 17'h1FFFF, 17'h15555, "R2");
    step(1'b0, 3'd6, 4'h1, 1'b0, 17'h1FFFF, 17'h15555, "R6");
    step(1'b0, 3'd7, 4'h0, 1'b1, 17'h00000, 17'h13579, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule